// File: doc/BRIEF.md
# PWM Channel with Double-Buffered Updates

This block generates one pulse-width-modulated signal and drives it out as a complementary pair, a high-side output and a low-side output. A period counter advances on every cycle in which the `tick` enable is high. The counter either wraps from the top back to zero (left alignment) or counts up to the period value and back down again (center alignment). The waveform is active while the count is below the duty value. A polarity bit sets the active level. Each side then passes through its own dead-time delay, which holds back only the rising edge, and through its own inversion bit.

Period, duty and dead-time values are written through one data bus with a write strobe for each register. While the channel is stopped, a write reaches the active value at once. While it runs, a write lands in a shadow copy. All shadow copies are transferred to the active values together at the next period boundary, so a running waveform never shows a half-updated setting. The `en_req` and `dis_req` strobes start and stop the channel. A stop request waits for the end of the current period, and `running` shows the true run state throughout. A period event sets a sticky flag, which drives `irq` when the interrupt is enabled.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset `running`, `irq_flag` and `irq` are 0, `out_h` is 0 and `out_l` is 1.
- R2: `en_req` while stopped sets `running` at the next clock edge, and the count restarts from 0 at that edge; later ticks advance it from there.
- R3: With mode bit 0 clear (left alignment), the count runs 0..P-1 and wraps to 0, where P is the active period (a period of 0 acts as 1); the waveform is active while count < duty.
- R4: With mode bit 0 set (center alignment), the count runs up from 0 to P and back down to 1, giving a period of 2P ticks; the waveform is active while count < duty; the period boundary is the step back to 0.
- R5: Mode bit 1 clear makes the high-side reference equal to the waveform; set makes it the inverse; the low-side reference is always the complement of the high-side reference.
- R6: With mode bit 3 set, each side goes active only after its reference has been active for its dead-time count of ticks; the dead-time word carries the high-side count in wdata[CW-1:0] and the low-side count in wdata[2CW-1:CW]; a falling reference takes effect at once.
- R7: Mode bits 4 and 5 invert `out_h` and `out_l` after dead-time insertion.
- R8: Period, duty and dead-time writes while stopped take effect at the next edge; writes while running change nothing until the next period boundary, where all three are applied.
- R9: `dis_req` while running leaves `running` at 1 until the next period boundary, then clears it and returns both outputs to their idle levels.
- R10: Mode writes (`mode_we`, wdata[5:0]) are ignored while the channel is running.
- R11: Every period boundary sets `irq_flag`; `irq_ack` clears it, but a boundary in the same cycle wins; `irq` is `irq_flag` gated by an enable that `irq_en_set` sets and `irq_en_clr` clears.
- R12: With mode bit 2 set in center alignment, the turn at the top of the count also sets `irq_flag`.
- R13: Before inversion, the high side and the low side are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| en_req | input | 1 | Start strobe |
| dis_req | input | 1 | Stop strobe (takes effect at the period boundary) |
| mode_we | input | 1 | Mode write strobe |
| per_we | input | 1 | Period write strobe |
| duty_we | input | 1 | Duty write strobe |
| dt_we | input | 1 | Dead-time write strobe |
| wdata | input | 2*CW | Write data |
| irq_en_set | input | 1 | Interrupt enable set strobe |
| irq_en_clr | input | 1 | Interrupt enable clear strobe |
| irq_ack | input | 1 | Clears the period flag |
| running | output | 1 | Channel run state |
| out_h | output | 1 | High-side output |
| out_l | output | 1 | Low-side output |
| irq_flag | output | 1 | Sticky period-event flag |
| irq | output | 1 | Flag gated by interrupt enable |

## Verification
The hardest situation to reach is a write or stop request that arrives mid-period on a running channel. Its effect must stay hidden for an exact number of ticks and then appear at the boundary and nowhere else. The stimulus places each such strobe at a known count within a short period and samples every following cycle against the arithmetic count model. This pins down both the cycles that must keep the old behaviour and the first cycle of the new one. Exhaustive sweeps over small periods, every duty value, both alignments and a grid of dead-time pairs cover the waveform itself.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  localparam int MODE_W = 6;

  // Bit order matters: the write data maps onto it directly (bit 0 = center).
  typedef struct packed {
    logic inv_l;    // bit 5
    logic inv_h;    // bit 4
    logic dt_en;    // bit 3
    logic ev_top;   // bit 2
    logic act_low;  // bit 1
    logic center;   // bit 0
  } pwm_mode_t;

  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} pwm_dir_t;

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            running,
  input  logic            boundary,
  input  logic            mode_we,
  input  logic            per_we,
  input  logic            duty_we,
  input  logic            dt_we,
  input  logic [2*CW-1:0] wdata,
  output pwm_mode_t       mode,
  output logic [CW-1:0]   period,
  output logic [CW-1:0]   duty,
  output logic [CW-1:0]   dt_h,
  output logic [CW-1:0]   dt_l
);

  localparam int NF = 4;  // period, duty, dead-time high, dead-time low

  pwm_mode_t       mode_q;
  logic [NF-1:0]   fld_we;
  logic [CW-1:0]   fld_wd  [NF];
  logic [CW-1:0]   act_q   [NF];
  logic [CW-1:0]   shd_q   [NF];

  assign fld_we = {dt_we, dt_we, duty_we, per_we};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mode_q <= '0;
    else if (mode_we && !running) mode_q <= pwm_mode_t'(wdata[MODE_W-1:0]);
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    if (i == NF - 1) begin : g_hi
      assign fld_wd[i] = wdata[2*CW-1:CW];
    end else begin : g_lo
      assign fld_wd[i] = wdata[CW-1:0];
    end

    // Shadow mirrors every write; the boundary copies shadow to active.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[i] <= '0;
        shd_q[i] <= '0;
      end else begin
        if (boundary) act_q[i] <= shd_q[i];
        if (fld_we[i]) begin
          shd_q[i] <= fld_wd[i];
          if (!running) act_q[i] <= fld_wd[i];
        end
      end
    end

    a_r8_active_held: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !$past(boundary)) |-> $stable(act_q[i]));
  end

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(mode_q));

  assign mode   = mode_q;
  assign period = act_q[0];
  assign duty   = act_q[1];
  assign dt_h   = act_q[2];
  assign dt_l   = act_q[3];

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          center,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          boundary,
  output logic          top_evt
);

  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] eff_period(input logic [CW-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  logic [CW-1:0] cnt_q, nxt_c, pe;
  pwm_dir_t      dir_q, dir_n;
  logic          turn_c, wrap_c;

  assign pe = eff_period(period);

  always_comb begin
    turn_c = center && (dir_q == DIR_UP) && (cnt_q >= pe);
    wrap_c = 1'b0;
    dir_n  = DIR_UP;
    nxt_c  = cnt_q + ONE;
    if (!center) begin
      if (cnt_q >= pe - ONE) begin
        nxt_c  = '0;
        wrap_c = 1'b1;
      end
    end else if (dir_q == DIR_UP && !turn_c) begin
      nxt_c = cnt_q + ONE;
    end else if (cnt_q <= ONE) begin
      nxt_c  = '0;
      wrap_c = 1'b1;
    end else begin
      nxt_c = cnt_q - ONE;
      dir_n = DIR_DN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!run) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick) begin
      cnt_q <= nxt_c;
      dir_q <= dir_n;
    end
  end

  assign cnt      = cnt_q;
  assign boundary = run && tick && wrap_c;
  assign top_evt  = run && tick && turn_c;

  // R3 and R4: count stays inside the active period range
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= pe));

endmodule

// File: rtl/pwm_dbuf_deadband.sv
module pwm_dbuf_deadband #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] dly,
  input  logic          ref_in,
  output logic          out
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] rem_q;

  // Reload while the reference is inactive, count down while it is active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rem_q <= '0;
    else if (!ref_in)                 rem_q <= dly;
    else if (tick && rem_q != '0)     rem_q <= rem_q - ONE;
  end

  assign out = ref_in && (!en || rem_q == '0);

  a_r6_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out) && en && $past(en) && $past(dly) != '0) |-> $past(ref_in));

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en_req,
  input  logic            dis_req,
  input  logic            mode_we,
  input  logic            per_we,
  input  logic            duty_we,
  input  logic            dt_we,
  input  logic [2*CW-1:0] wdata,
  input  logic            irq_en_set,
  input  logic            irq_en_clr,
  input  logic            irq_ack,
  output logic            running,
  output logic            out_h,
  output logic            out_l,
  output logic            irq_flag,
  output logic            irq
);

  localparam int NSIDE = 2;

  pwm_mode_t     mode;
  logic [CW-1:0] period, duty, dt_h, dt_l, cnt;
  logic          running_q, dis_pend_q, irq_en_q, irq_flag_q;
  logic          boundary, top_evt, period_evt, wave_act, h_ref;
  logic [NSIDE-1:0] side_ref, side_out, side_inv;
  logic [CW-1:0]    side_dt [NSIDE];

  pwm_dbuf_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .running(running_q), .boundary(boundary),
    .mode_we(mode_we), .per_we(per_we), .duty_we(duty_we), .dt_we(dt_we),
    .wdata(wdata), .mode(mode), .period(period), .duty(duty),
    .dt_h(dt_h), .dt_l(dt_l)
  );

  pwm_dbuf_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running_q), .tick(tick),
    .center(mode.center), .period(period), .cnt(cnt),
    .boundary(boundary), .top_evt(top_evt)
  );

  // Run control: stop waits for the boundary; a start cancels a pending stop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q  <= 1'b0;
      dis_pend_q <= 1'b0;
    end else if (!running_q) begin
      dis_pend_q <= 1'b0;
      if (en_req) running_q <= 1'b1;
    end else if (boundary && dis_pend_q) begin
      running_q  <= 1'b0;
      dis_pend_q <= 1'b0;
    end else if (en_req) begin
      dis_pend_q <= 1'b0;
    end else if (dis_req) begin
      dis_pend_q <= 1'b1;
    end
  end

  assign period_evt = boundary || (top_evt && mode.center && mode.ev_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= 1'b0;
      irq_flag_q <= 1'b0;
    end else begin
      if (irq_en_set)      irq_en_q <= 1'b1;
      else if (irq_en_clr) irq_en_q <= 1'b0;
      if (period_evt)      irq_flag_q <= 1'b1;
      else if (irq_ack)    irq_flag_q <= 1'b0;
    end
  end

  assign wave_act = running_q && (cnt < duty);
  assign h_ref    = wave_act ^ mode.act_low;
  assign side_ref = {~h_ref, h_ref};
  assign side_inv = {mode.inv_l, mode.inv_h};
  assign side_dt[0] = dt_h;
  assign side_dt[1] = dt_l;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    pwm_dbuf_deadband #(.CW(CW)) u_db (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(mode.dt_en),
      .dly(side_dt[s]), .ref_in(side_ref[s]), .out(side_out[s])
    );
  end

  assign out_h    = side_out[0] ^ side_inv[0];
  assign out_l    = side_out[1] ^ side_inv[1];
  assign running  = running_q;
  assign irq_flag = irq_flag_q;
  assign irq      = irq_flag_q && irq_en_q;

  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_q) |-> (cnt == '0));

  a_r9_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_q) |-> $past(boundary));

  a_r11_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_q) |-> $past(period_evt));

  a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(side_out[0] && side_out[1]));

endmodule

// File: tb/sim_pwm_dbuf_channel.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_channel;

  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic en_req = 0, dis_req = 0, mode_we = 0, per_we = 0, duty_we = 0, dt_we = 0;
  logic [2*CW-1:0] wdata = '0;
  logic irq_en_set = 0, irq_en_clr = 0, irq_ack = 0;
  logic running, out_h, out_l, irq_flag, irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_dbuf_channel #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_req(en_req), .dis_req(dis_req),
    .mode_we(mode_we), .per_we(per_we), .duty_we(duty_we), .dt_we(dt_we),
    .wdata(wdata), .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
    .irq_ack(irq_ack), .running(running), .out_h(out_h), .out_l(out_l),
    .irq_flag(irq_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // sel: 0 mode, 1 period, 2 duty, 3 dead time
  task automatic write_reg(input int sel, input int d);
    wdata = (2*CW)'(d);
    mode_we = (sel == 0); per_we = (sel == 1); duty_we = (sel == 2); dt_we = (sel == 3);
    @(negedge clk);
    {mode_we, per_we, duty_we, dt_we} = '0;
  endtask

  task automatic pulse(ref logic s); s = 1'b1; @(negedge clk); s = 1'b0; endtask

  function automatic int mode_word(bit ctr, bit alow, bit evt, bit dten, bit ih, bit il);
    return int'(ctr) | (int'(alow) << 1) | (int'(evt) << 2) | (int'(dten) << 3) |
           (int'(ih) << 4) | (int'(il) << 5);
  endfunction

  function automatic int ref_cnt(int k, int p, bit ctr);
    int pe = (p == 0) ? 1 : p;
    int ph;
    if (!ctr) return k % pe;
    ph = k % (2 * pe);
    return (ph <= pe) ? ph : 2 * pe - ph;
  endfunction

  function automatic bit href_at(int k, int p, int d, bit ctr, bit alow);
    bit a = (k >= 0) && (ref_cnt(k, p, ctr) < d);
    return a ^ alow;
  endfunction

  function automatic bit side_exp(int k, int p, int d, bit ctr, bit alow,
                                  bit low_side, bit dten, int dt);
    bit r = 1'b1;
    int span = dten ? dt : 0;
    for (int j = k - span; j <= k; j++) begin
      bit v = href_at(j, p, d, ctr, alow);
      if (low_side) v = !v;
      if (!v) r = 1'b0;
    end
    return r;
  endfunction

  task automatic setup(input int p, input int d, input int mw, input int dth, input int dtl);
    do_reset();
    write_reg(0, mw);
    write_reg(1, p);
    write_reg(2, d);
    write_reg(3, dth | (dtl << CW));
  endtask

  task automatic run_wave(input string tag, input int p, input int d, input bit ctr,
                          input bit alow, input bit dten, input int dth, input int dtl,
                          input bit ih, input bit il, input int ncyc);
    setup(p, d, mode_word(ctr, alow, 1'b0, dten, ih, il), dth, dtl);
    pulse(en_req);
    for (int k = 0; k < ncyc; k++) begin
      bit eh = side_exp(k, p, d, ctr, alow, 1'b0, dten, dth) ^ ih;
      bit el = side_exp(k, p, d, ctr, alow, 1'b1, dten, dtl) ^ il;
      chk({tag, " out_h"}, int'(out_h), int'(eh));
      chk({tag, " out_l"}, int'(out_l), int'(el));
      if (!ih && !il) chk("R13 no overlap", int'(out_h && out_l), 0);
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 running", int'(running), 0);
    chk("R1 out_h", int'(out_h), 0);
    chk("R1 out_l", int'(out_l), 1);
    chk("R1 irq_flag", int'(irq_flag), 0);
    chk("R1 irq", int'(irq), 0);

    // R3 left alignment, every duty for small periods (R2 start, R8 direct write)
    for (int p = 0; p <= 5; p++)
      for (int d = 0; d <= p; d++)
        run_wave("R3", p, d, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 13);
    // R4 center alignment
    for (int p = 1; p <= 4; p++)
      for (int d = 0; d <= p + 1; d++)
        run_wave("R4", p, d, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 18);
    // R5 polarity
    for (int d = 0; d <= 4; d++) begin
      run_wave("R5", 4, d, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 10);
      run_wave("R5", 3, d, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 14);
    end
    // R6 dead time grid, both polarities
    for (int a = 0; a < 2; a++)
      for (int dh = 0; dh <= 3; dh++)
        for (int dl = 0; dl <= 3; dl++)
          run_wave("R6", 8, 4, 1'b0, a[0], 1'b1, dh, dl, 1'b0, 1'b0, 26);
    run_wave("R6", 5, 2, 1'b1, 1'b0, 1'b1, 2, 1, 1'b0, 1'b0, 24);
    // R7 inversion after dead time
    run_wave("R7", 6, 3, 1'b0, 1'b0, 1'b1, 1, 2, 1'b1, 1'b0, 20);
    run_wave("R7", 6, 3, 1'b0, 1'b0, 1'b1, 2, 1, 1'b0, 1'b1, 20);
    run_wave("R7", 6, 2, 1'b0, 1'b1, 1'b0, 0, 0, 1'b1, 1'b1, 20);

    // R8 duty write while running waits for the boundary
    setup(4, 1, 0, 0, 0);
    pulse(en_req);
    chk("R8 k0", int'(out_h), 1); step();
    chk("R8 k1", int'(out_h), 0);
    write_reg(2, 3);
    chk("R8 k2 old duty", int'(out_h), 0); step();
    chk("R8 k3 old duty", int'(out_h), 0); step();
    chk("R8 k4 new duty", int'(out_h), 1); step();
    chk("R8 k5 new duty", int'(out_h), 1); step();
    chk("R8 k6 new duty", int'(out_h), 1); step();
    chk("R8 k7 new duty", int'(out_h), 0);

    // R9 stop waits for the boundary; R2 restart from zero
    setup(4, 2, 0, 0, 0);
    pulse(en_req);
    chk("R2 running", int'(running), 1);
    chk("R2 k0", int'(out_h), 1); step();
    pulse(dis_req);
    chk("R9 k2 running", int'(running), 1);
    chk("R9 k2 out_h", int'(out_h), 0); step();
    chk("R9 k3 running", int'(running), 1); step();
    chk("R9 k4 running", int'(running), 0);
    chk("R9 k4 out_h", int'(out_h), 0);
    chk("R9 k4 out_l", int'(out_l), 1); step();
    chk("R9 k5 running", int'(running), 0);
    pulse(en_req);
    chk("R2 restart running", int'(running), 1);
    chk("R2 restart k0", int'(out_h), 1); step();
    chk("R2 restart k1", int'(out_h), 1); step();
    chk("R2 restart k2", int'(out_h), 0);

    // R10 mode write while running is ignored
    setup(4, 2, 0, 0, 0);
    pulse(en_req);
    write_reg(0, mode_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    for (int k = 1; k < 8; k++) begin
      chk("R10 out_h", int'(out_h), int'((k % 4) < 2));
      chk("R10 out_l", int'(out_l), int'((k % 4) >= 2));
      step();
    end

    // R11 flag, enable, acknowledge
    setup(3, 1, 0, 0, 0);
    pulse(en_req);
    chk("R11 k0 flag", int'(irq_flag), 0); step();
    chk("R11 k1 flag", int'(irq_flag), 0); step();
    chk("R11 k2 flag", int'(irq_flag), 0); step();
    chk("R11 k3 flag", int'(irq_flag), 1);
    chk("R11 k3 irq masked", int'(irq), 0);
    pulse(irq_en_set);
    chk("R11 k4 irq", int'(irq), 1);
    pulse(irq_ack);
    chk("R11 k5 flag cleared", int'(irq_flag), 0);
    chk("R11 k5 irq", int'(irq), 0); step();
    chk("R11 k6 flag", int'(irq_flag), 1);
    chk("R11 k6 irq", int'(irq), 1);
    pulse(irq_en_clr);
    chk("R11 k7 irq off", int'(irq), 0);
    chk("R11 k7 flag kept", int'(irq_flag), 1);
    pulse(irq_ack);
    chk("R11 k8 flag cleared", int'(irq_flag), 0);
    pulse(irq_ack);
    chk("R11 k9 boundary wins", int'(irq_flag), 1);

    // R12 top event in center alignment
    setup(3, 0, mode_word(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 0, 0);
    pulse(en_req);
    repeat (3) step();
    chk("R12 k3 flag", int'(irq_flag), 0); step();
    chk("R12 k4 top flag", int'(irq_flag), 1);
    setup(3, 0, mode_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 0, 0);
    pulse(en_req);
    repeat (4) step();
    chk("R12 k4 no top flag", int'(irq_flag), 0); step(); step();
    chk("R12 k6 bottom flag", int'(irq_flag), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule